// File: doc/BRIEF.md
# Pipelined ADC Scan Controller

This block is a serial-interface master for a multichannel successive-approximation converter whose answers trail its commands. It runs one of two jobs on request. A scan converts every channel enabled in a 16-bit mask. A single read converts one named channel. Each 16-bit word travels in its own chip-select frame, in SPI mode 0 with the most significant bit first. The serial clock comes from the system clock through an even divider.

The converter samples a channel at the end of the frame that carries its command. It converts the sample during the next frame and returns it in the frame after that. The controller therefore keeps a two-deep record of the channels it has requested. It pairs each returned word with the command sent two frames earlier. It checks the channel tag in the word and extracts the sample at the configured resolution. Each result is presented for one cycle as a channel, a value and an error flag.

The channel count and the resolution are parameters. Mask bits above the channel count have no effect.

Top module: `adc_scan_ctrl`

## Requirements
- R1: Each word is one frame. Chip select goes low, then exactly 16 serial-clock rising edges occur, and chip select goes high again. The serial clock idles low whenever chip select is high. Data is sampled on rising edges, and chip select stays high for at least CLK_DIV system cycles between frames.
- R2: A command word has bit 12 = 1 (manual channel select), bit 11 = 1 (settings write), bits 10:7 = channel number, bit 6 = `range_dbl_i` captured at start, and every other bit 0.
- R3: A scan sends one command per enabled channel, from the lowest channel to the highest, and then two all-zero words. A scan has popcount(enabled mask) + 2 frames.
- R4: Every result carries the channel of the command sent two frames before the word it was taken from. The words received in the first two frames produce no result, and each command produces exactly one result.
- R5: A single read uses three frames. The first two frames carry the command for `chan_i`, and the third carries zero. Only the word received in the third frame is reported, tagged `chan_i`.
- R6: `res_err_o` is 1 with a result exactly when bits 15:12 of the received word differ from the expected channel.
- R7: `res_data_o` equals bits [11:12-RES_BITS] of the received word.
- R8: Mask bits at positions NUM_CH and above are ignored. A scan whose remaining mask is empty sends no frames and raises `done_o` in the cycle after the start request.
- R9: `start_i` is accepted only while `busy_o` is 0, and is ignored at all other times, including the done cycle. `busy_o` is 1 from the cycle after acceptance through the cycle in which `done_o` is high.
- R10: `done_o` pulses for one cycle, in the cycle after the last result is presented, and never in the same cycle as a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one cycle |
| single_i | input | 1 | 1 = single read, 0 = mask scan |
| chan_i | input | 4 | Channel for a single read |
| mask_i | input | 16 | Channel enable mask for a scan |
| range_dbl_i | input | 1 | Doubled input range setting placed in bit 6 of each command |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| res_valid_o | output | 1 | Result present this cycle |
| res_chan_o | output | 4 | Channel the result belongs to |
| res_data_o | output | RES_BITS | Extracted sample |
| res_err_o | output | 1 | Returned channel tag mismatch |

## Verification
A new start request can arrive in the same cycle that the controller presents `done_o`, or while frames are still in flight. The bench provokes the first case by raising `start_i` exactly in the done cycle of every sequence. It judges the outcome by requiring `busy_o` to be low in the following cycle, with no frame and no result after it. It provokes the mid-sequence case with a conflicting mask. There, the command log and the scoreboard must both match the original request and nothing else. The bench also uses the recorded result and done cycles to confirm that the last result and the done pulse fall in consecutive cycles and never in the same cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int WORD_W   = 16;
    localparam int CHAN_W   = 4;
    localparam int MAX_CH   = 16;
    localparam int SMP_W    = 12;
    localparam int TAG_LSB  = 12;
    localparam int MAN_BIT  = 12;
    localparam int PROG_BIT = 11;
    localparam int CH_LSB   = 7;
    localparam int DBL_BIT  = 6;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CHAN_W-1:0] chan_t;

    typedef struct packed {
        logic  vld;
        chan_t ch;
    } tag_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DRAIN, SQ_FIN} seq_state_e;
    typedef enum logic [1:0] {EN_IDLE, EN_SHIFT, EN_GAP} eng_state_e;

    function automatic word_t make_cmd(chan_t ch, logic dbl);
        word_t w;
        w = '0;
        w[MAN_BIT] = 1'b1;
        w[PROG_BIT] = 1'b1;
        w[CH_LSB +: CHAN_W] = ch;
        w[DBL_BIT] = dbl;
        return w;
    endfunction

    function automatic chan_t first_set(logic [MAX_CH-1:0] m);
        chan_t r;
        r = '0;
        for (int i = MAX_CH - 1; i >= 0; i--) begin
            if (m[i]) r = chan_t'(i);
        end
        return r;
    endfunction

    function automatic logic [MAX_CH-1:0] usable_mask(int n);
        logic [MAX_CH-1:0] m;
        for (int i = 0; i < MAX_CH; i++) m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/adc_spi_engine.sv
module adc_spi_engine
    import adc_scan_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  go_i,
    input  word_t tx_i,
    output logic  ready_o,
    output logic  done_o,
    output word_t rx_o,
    output logic  sclk_o,
    output logic  cs_n_o,
    output logic  mosi_o,
    input  logic  miso_i
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PW   = $clog2(CLK_DIV + 1);

    eng_state_e st;
    logic [PW-1:0] ph;
    logic [3:0] bitc;
    word_t tx_sh, rx_sh;

    assign ready_o = (st == EN_IDLE);
    assign mosi_o  = tx_sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= EN_IDLE;
            cs_n_o <= 1'b1;
            sclk_o <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            ph     <= '0;
            bitc   <= '0;
            done_o <= 1'b0;
            rx_o   <= '0;
        end else begin
            done_o <= 1'b0;
            case (st)
                EN_IDLE: begin
                    if (go_i) begin
                        st     <= EN_SHIFT;
                        cs_n_o <= 1'b0;
                        sclk_o <= 1'b0;
                        tx_sh  <= tx_i;
                        ph     <= '0;
                        bitc   <= '0;
                    end
                end
                EN_SHIFT: begin
                    if (ph == PW'(HALF - 1)) begin
                        ph <= '0;
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                            rx_sh  <= {rx_sh[WORD_W-2:0], miso_i};
                        end else begin
                            sclk_o <= 1'b0;
                            if (bitc == 4'd15) begin
                                cs_n_o <= 1'b1;
                                done_o <= 1'b1;
                                rx_o   <= rx_sh;
                                st     <= EN_GAP;
                            end else begin
                                bitc  <= bitc + 4'd1;
                                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        ph <= ph + PW'(1);
                    end
                end
                EN_GAP: begin
                    if (ph == PW'(CLK_DIV - 1)) begin
                        ph <= '0;
                        st <= EN_IDLE;
                    end else begin
                        ph <= ph + PW'(1);
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    // R1
    word_end_cs_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> cs_n_o);

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              single_i,
    input  chan_t             chan_i,
    input  logic [MAX_CH-1:0] mask_i,
    input  logic              dbl_i,
    input  logic              eng_ready_i,
    input  logic              eng_done_i,
    output logic              go_o,
    output word_t             tx_o,
    output tag_t              tag_o,
    output logic              clr_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [MAX_CH-1:0] USE = usable_mask(NUM_CH);

    seq_state_e st;
    logic [MAX_CH-1:0] rem;
    logic [1:0] pads, sidx;
    logic sgl, dbl, all_issued, last;
    chan_t sch, nxt;
    logic start_ok;
    logic [MAX_CH-1:0] eff;

    assign start_ok = (st == SQ_IDLE) && start_i;
    assign eff      = mask_i & USE;
    assign nxt      = first_set(rem);
    assign go_o     = (st == SQ_RUN) && eng_ready_i && !all_issued;
    assign clr_o    = start_ok;
    assign busy_o   = (st != SQ_IDLE);
    assign done_o   = (st == SQ_FIN);

    always_comb begin
        if (sgl) begin
            tx_o  = (sidx < 2'd2) ? make_cmd(sch, dbl) : '0;
            tag_o = '{vld: (sidx == 2'd0), ch: sch};
            last  = (sidx == 2'd2);
        end else if (rem != '0) begin
            tx_o  = make_cmd(nxt, dbl);
            tag_o = '{vld: 1'b1, ch: nxt};
            last  = 1'b0;
        end else begin
            tx_o  = '0;
            tag_o = '{vld: 1'b0, ch: '0};
            last  = (pads == 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            rem        <= '0;
            pads       <= '0;
            sidx       <= '0;
            sgl        <= 1'b0;
            dbl        <= 1'b0;
            sch        <= '0;
            all_issued <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start_ok) begin
                        sgl        <= single_i;
                        sch        <= chan_i;
                        dbl        <= dbl_i;
                        rem        <= eff;
                        pads       <= 2'd2;
                        sidx       <= '0;
                        all_issued <= 1'b0;
                        st <= (!single_i && eff == '0) ? SQ_FIN : SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (go_o) begin
                        if (sgl)              sidx <= sidx + 2'd1;
                        else if (rem != '0)   rem  <= rem & ~(MAX_CH'(1) << nxt);
                        else                  pads <= pads - 2'd1;
                        if (last) all_issued <= 1'b1;
                    end
                    if (all_issued && eng_done_i) st <= SQ_DRAIN;
                end
                SQ_DRAIN: st <= SQ_FIN;
                SQ_FIN:   st <= SQ_IDLE;
                default:  st <= SQ_IDLE;
            endcase
        end
    end

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R8
    empty_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !single_i && ((mask_i & USE) == '0)) |=> done_o);

    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

endmodule

// File: rtl/adc_result_align.sv
module adc_result_align
    import adc_scan_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                go_i,
    input  tag_t                tag_i,
    input  logic                done_i,
    input  word_t               rx_i,
    output logic                res_valid_o,
    output chan_t               res_chan_o,
    output logic [RES_BITS-1:0] res_data_o,
    output logic                res_err_o
);
    localparam int DROP = SMP_W - RES_BITS;

    tag_t pend, p0, p1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend        <= '0;
            p0          <= '0;
            p1          <= '0;
            res_valid_o <= 1'b0;
            res_chan_o  <= '0;
            res_data_o  <= '0;
            res_err_o   <= 1'b0;
        end else begin
            if (clr_i) begin
                pend <= '0;
                p0   <= '0;
                p1   <= '0;
            end else if (go_i) begin
                pend <= tag_i;
            end
            if (done_i && !clr_i) begin
                res_valid_o <= p1.vld;
                res_chan_o  <= p1.ch;
                res_data_o  <= RES_BITS'(rx_i[SMP_W-1:0] >> DROP);
                res_err_o   <= p1.vld && (rx_i[TAG_LSB +: CHAN_W] != p1.ch);
                p1 <= p0;
                p0 <= pend;
            end else begin
                res_valid_o <= 1'b0;
                res_err_o   <= 1'b0;
            end
        end
    end

    // R4
    result_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(done_i));

    // R6
    err_with_result_chk: assert property (@(posedge clk) disable iff (rst)
        res_err_o |-> res_valid_o);

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int RES_BITS = 12,
    parameter int CLK_DIV  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                single_i,
    input  logic [3:0]          chan_i,
    input  logic [15:0]         mask_i,
    input  logic                range_dbl_i,
    input  logic                miso_i,
    output logic                sclk_o,
    output logic                cs_n_o,
    output logic                mosi_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                res_valid_o,
    output logic [3:0]          res_chan_o,
    output logic [RES_BITS-1:0] res_data_o,
    output logic                res_err_o
);
    logic  go, eng_ready, eng_done, clr;
    word_t tx_word, rx_word;
    tag_t  tag;

    adc_scan_sequencer #(.NUM_CH(NUM_CH)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .single_i(single_i),
        .chan_i(chan_i), .mask_i(mask_i), .dbl_i(range_dbl_i),
        .eng_ready_i(eng_ready), .eng_done_i(eng_done),
        .go_o(go), .tx_o(tx_word), .tag_o(tag), .clr_o(clr),
        .busy_o(busy_o), .done_o(done_o)
    );

    adc_spi_engine #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst(rst), .go_i(go), .tx_i(tx_word),
        .ready_o(eng_ready), .done_o(eng_done), .rx_o(rx_word),
        .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    adc_result_align #(.RES_BITS(RES_BITS)) u_align (
        .clk(clk), .rst(rst), .clr_i(clr), .go_i(go), .tag_i(tag),
        .done_i(eng_done), .rx_i(rx_word),
        .res_valid_o(res_valid_o), .res_chan_o(res_chan_o),
        .res_data_o(res_data_o), .res_err_o(res_err_o)
    );

    // R10
    done_apart_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, res_valid_o}));

endmodule

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;
    localparam int NC  = 8;
    localparam int RB  = 10;
    localparam int DIV = 4;

    typedef struct packed {
        logic [3:0]    ch;
        logic [RB-1:0] d;
        logic          e;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, single = 1'b0, dbl = 1'b0, miso = 1'b0;
    logic [3:0] chan = '0;
    logic [15:0] mask = '0;
    logic sclk, cs_n, mosi, busy, done, rvalid, rerr;
    logic [3:0] rchan;
    logic [RB-1:0] rdata;

    int checks = 0, fails = 0;
    int cyc = 0, frames = 0, rise_cyc = 0, last_valid_cyc = -10, rises = 0;
    logic armed = 1'b0;
    logic [7:0] salt = '0;
    logic bad_en = 1'b0;
    logic [3:0] bad_ch = '0;
    logic [15:0] cap = '0, out_w = '0, pipe0 = '0, pipe1 = '0;
    logic [15:0] cmdlog[$];
    exp_t expq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_scan_ctrl #(.NUM_CH(NC), .RES_BITS(RB), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .start_i(start), .single_i(single),
        .chan_i(chan), .mask_i(mask), .range_dbl_i(dbl), .miso_i(miso),
        .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .busy_o(busy),
        .done_o(done), .res_valid_o(rvalid), .res_chan_o(rchan),
        .res_data_o(rdata), .res_err_o(rerr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cmd_of(input logic [3:0] c, input logic d);
        return 16'h1800 | (16'(c) << 7) | (16'(d) << 6);
    endfunction

    // converter model: mode 0 slave with a two-frame result latency
    always @(negedge cs_n) begin
        if (armed) begin
            if (frames > 0) chk((cyc - rise_cyc) >= DIV, "R1", "cs high gap", cyc - rise_cyc, DIV);
            rises = 0;
            out_w = pipe1;
            miso = pipe1[15];
        end
    end
    always @(posedge sclk) begin
        if (!cs_n) begin
            cap = {cap[14:0], mosi};
            rises++;
        end
    end
    always @(negedge sclk) begin
        if (!cs_n && rises < 16) miso = out_w[15 - rises];
    end
    always @(posedge cs_n) begin
        if (armed) begin
            logic [3:0] sc, tg;
            chk(rises == 16, "R1", "sclk edges per frame", rises, 16);
            cmdlog.push_back(cap);
            frames++;
            rise_cyc = cyc;
            sc = cap[12] ? cap[10:7] : 4'd0;
            tg = (bad_en && sc == bad_ch) ? (sc ^ 4'd1) : sc;
            pipe1 = pipe0;
            pipe0 = {tg, sc, salt};
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            last_valid_cyc = cyc;
            if (expq.size() == 0) begin
                chk(1'b0, "R4", "unexpected result channel", rchan, 0);
            end else begin
                exp_t x;
                x = expq.pop_front();
                chk(rchan == x.ch, "R4", "result channel", rchan, x.ch);
                chk(rdata == x.d, "R7", "result data", rdata, x.d);
                chk(rerr == x.e, "R6", "error flag", rerr, x.e);
            end
        end
    end

    task automatic push_exp(input logic [3:0] c);
        exp_t x;
        logic [11:0] s;
        s = {c, salt};
        x.ch = c;
        x.d = s[11:12-RB];
        x.e = bad_en && (c == bad_ch);
        expq.push_back(x);
    endtask

    task automatic run_seq(input logic sg, input logic [3:0] c, input logic [15:0] m,
                           input logic d, input logic poke);
        logic [15:0] expc[$];
        int done_cyc, n;
        n = 0;
        if (sg) begin
            expc.push_back(cmd_of(c, d));
            expc.push_back(cmd_of(c, d));
            expc.push_back(16'h0);
            push_exp(c);
            n = 1;
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (m[i] && i < NC) begin
                    expc.push_back(cmd_of(4'(i), d));
                    push_exp(4'(i));
                    n++;
                end
            end
            if (n > 0) begin
                expc.push_back(16'h0);
                expc.push_back(16'h0);
            end
        end
        cmdlog.delete();
        frames = 0;
        @(negedge clk);
        single = sg; chan = c; mask = m; dbl = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R8", "empty scan done next cycle", done, 1);
        end else begin
            chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
            for (int k = 0; k < 100000 && !done; k++) begin
                if (poke && k == 20) begin
                    mask = 16'h00FF; single = 1'b0; start = 1'b1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
            start = 1'b0;
        end
        done_cyc = cyc;
        chk(busy == 1'b1, "R9", "busy in done cycle", busy, 1);
        if (n > 0) chk(last_valid_cyc == done_cyc - 1, "R10", "done after last result",
                       done_cyc - last_valid_cyc, 1);
        // start raised exactly in the done cycle must be ignored
        mask = 16'h0001; single = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R10", "done lasts one cycle", done, 0);
        chk(busy == 1'b0, "R9", "start in done cycle ignored", busy, 0);
        repeat (3 * DIV) @(negedge clk);
        chk(expq.size() == 0, "R4", "results left pending", expq.size(), 0);
        chk(frames == expc.size(), sg ? "R5" : "R3", "frame count", frames, expc.size());
        for (int i = 0; i < expc.size() && i < cmdlog.size(); i++)
            chk(cmdlog[i] == expc[i], sg ? "R5" : "R2", "command word", cmdlog[i], expc[i]);
        if (n == 0) chk(frames == 0, "R8", "no frames on empty mask", frames, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", "run timed out", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
        chk(busy == 1'b0, "R9", "reset busy", busy, 0);
        chk(done == 1'b0 && rvalid == 1'b0, "R10", "reset done/valid", {done, rvalid}, 0);

        salt = 8'h3B; run_seq(1'b0, 4'd0, 16'h00A5, 1'b1, 1'b0);        // R3 sparse scan
        salt = 8'h92; run_seq(1'b0, 4'd0, 16'hFF0C, 1'b0, 1'b1);        // R8 upper bits, R9 mid start
        salt = 8'hC6; bad_en = 1'b1; bad_ch = 4'd5;
        run_seq(1'b0, 4'd0, 16'hFFFF, 1'b1, 1'b0);                      // R6 on channel 5
        bad_en = 1'b0;
        salt = 8'h5D; run_seq(1'b1, 4'd6, 16'h0000, 1'b1, 1'b0);        // R5 single read
        salt = 8'hA7; bad_en = 1'b1; bad_ch = 4'd3;
        run_seq(1'b1, 4'd3, 16'h0000, 1'b0, 1'b0);                      // R5 R6 single error
        bad_en = 1'b0;
        run_seq(1'b0, 4'd0, 16'hFF00, 1'b0, 1'b0);                      // R8 empty mask
        salt = 8'h1F; run_seq(1'b0, 4'd0, 16'h0080, 1'b1, 1'b0);        // R7 top channel
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule